// File: doc/BRIEF.md
# Parallel FFT DC-Bin Error Detector

This block watches a group of four 4-point FFT engines that run side by side. It flags any engine whose output looks corrupted. For each engine it adds the four time-domain input samples and compares the sum with the engine's DC output bin. A correct transform of real data yields a DC bin whose real part equals that sum and whose imaginary part is zero. Any difference marks the engine as faulty. The check reuses data that already exists and needs only one adder tree and one comparator per engine, with no multipliers.

A producer presents all sixteen samples and the four DC bins together and raises `in_valid` for one cycle. One cycle later the block raises `out_valid` for exactly one cycle and presents a per-engine error vector and a summary flag. Each engine is checked on its own, so several faulty engines can be flagged at once. The flags stay as they are until the next strobe. Correcting the faulty output and computing the transform are left to the surrounding logic.

`rst_n` is asserted asynchronously and is expected to be released in step with `clk`.

Top module: `fft_dc_err_det`

## Requirements
- R1: While reset is held and on the first edge after it, `out_valid`, `err_flags` and `any_err` are all 0.
- R2: `out_valid` is 1 in the cycle after an edge at which `in_valid` was 1, and 0 after an edge at which `in_valid` was 0.
- R3: The samples of engine l are packed in `samples` at bits `[(l*4+k)*6 +: 6]`, where k = 0..3, each as a 6-bit two's-complement value. The block sets `err_flags[l]` when the 8-bit two's-complement sum of these samples differs from `dc_re[l*8 +: 8]`.
- R4: `err_flags[l]` is set whenever `dc_im[l*8 +: 8]` is nonzero, even if the real part matches.
- R5: `err_flags[l]` is clear when the real part equals the sum and the imaginary part is zero. This includes the extreme sums -128 (all samples -32) and 124 (all samples 31).
- R6: The engines are judged independently. Any subset of the bits of `err_flags` can be set at the same time, and bit l reports only engine l.
- R7: `any_err` is 1 exactly when at least one bit of `err_flags` is 1.
- R8: While `in_valid` is 0, changes on `samples`, `dc_re` and `dc_im` have no effect, and `err_flags` and `any_err` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Samples and DC bins are valid this cycle |
| samples | input | 96 | Time-domain samples of all four engines, four 6-bit samples per engine |
| dc_re | input | 32 | Real part of each engine's DC bin, 8 bits per engine |
| dc_im | input | 32 | Imaginary part of each engine's DC bin, 8 bits per engine |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| err_flags | output | 4 | Per-engine fault flag, bit l for engine l |
| any_err | output | 1 | OR of the per-engine fault flags |

## Verification
The bench builds the block with its default parameters: four engines, four points and 6-bit samples, which gives an 8-bit DC bin. These values put the exact edges of the 8-bit range within reach, so the all-minimum and all-maximum sample patterns show whether the growth bits are sized without overflow. With four lanes the bench can also drive single, paired and imaginary-only faults. It also checks that the result holds steady while the strobe is low, and that results are taken correctly from back-to-back strobes.

// File: rtl/fft_dc_err_pkg.sv
package fft_dc_err_pkg;
  localparam int unsigned DEF_LANES  = 4;
  localparam int unsigned DEF_POINTS = 4;
  localparam int unsigned DEF_SMP_W  = 6;

  function automatic int unsigned growth_bits(input int unsigned points);
    return $clog2(points);
  endfunction
endpackage

// File: rtl/fft_dc_sum_tree.sv
module fft_dc_sum_tree #(
  parameter int unsigned POINTS = 4,
  parameter int unsigned SMP_W  = 6,
  parameter int unsigned ACC_W  = 8
) (
  input  logic [POINTS*SMP_W-1:0] smp_vec,
  output logic [ACC_W-1:0]        total
);
  logic [ACC_W-1:0] ext [POINTS];

  for (genvar k = 0; k < POINTS; k++) begin : g_ext
    assign ext[k] = {{(ACC_W-SMP_W){smp_vec[k*SMP_W+SMP_W-1]}},
                     smp_vec[k*SMP_W +: SMP_W]};
  end

  always_comb begin
    total = '0;
    for (int k = 0; k < POINTS; k++) begin
      total = total + ext[k];
    end
  end
endmodule

// File: rtl/fft_dc_lane_check.sv
module fft_dc_lane_check #(
  parameter int unsigned POINTS = 4,
  parameter int unsigned SMP_W  = 6,
  parameter int unsigned ACC_W  = 8
) (
  input  logic [POINTS*SMP_W-1:0] smp_vec,
  input  logic [ACC_W-1:0]        bin_re,
  input  logic [ACC_W-1:0]        bin_im,
  output logic                    mismatch
);
  logic [ACC_W-1:0] total;

  fft_dc_sum_tree #(
    .POINTS (POINTS),
    .SMP_W  (SMP_W),
    .ACC_W  (ACC_W)
  ) u_sum (
    .smp_vec (smp_vec),
    .total   (total)
  );

  always_comb begin
    mismatch = (total != bin_re) || (bin_im != '0);
  end
endmodule

// File: rtl/fft_dc_err_det.sv
module fft_dc_err_det
  import fft_dc_err_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned POINTS = DEF_POINTS,
  parameter int unsigned SMP_W  = DEF_SMP_W,
  localparam int unsigned ACC_W = SMP_W + growth_bits(POINTS),
  localparam int unsigned LANE_SMP_W = POINTS * SMP_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [LANES*LANE_SMP_W-1:0] samples,
  input  logic [LANES*ACC_W-1:0]      dc_re,
  input  logic [LANES*ACC_W-1:0]      dc_im,
  output logic                        out_valid,
  output logic [LANES-1:0]            err_flags,
  output logic                        any_err
);
  logic [LANES-1:0] lane_bad;
  logic [LANES-1:0] flags_d, flags_q;
  logic             any_d, any_q;
  logic             vld_d, vld_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    fft_dc_lane_check #(
      .POINTS (POINTS),
      .SMP_W  (SMP_W),
      .ACC_W  (ACC_W)
    ) u_chk (
      .smp_vec  (samples[l*LANE_SMP_W +: LANE_SMP_W]),
      .bin_re   (dc_re[l*ACC_W +: ACC_W]),
      .bin_im   (dc_im[l*ACC_W +: ACC_W]),
      .mismatch (lane_bad[l])
    );

    // R4: a nonzero imaginary DC part always ends up in the lane flag
    a_r4_imag_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (dc_im[l*ACC_W +: ACC_W] != '0)) |=> err_flags[l]);
  end

  always_comb begin
    vld_d   = in_valid;
    flags_d = flags_q;
    any_d   = any_q;
    if (in_valid) begin
      flags_d = lane_bad;
      any_d   = |lane_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      flags_q <= '0;
      any_q   <= 1'b0;
    end else begin
      vld_q   <= vld_d;
      flags_q <= flags_d;
      any_q   <= any_d;
    end
  end

  assign out_valid = vld_q;
  assign err_flags = flags_q;
  assign any_err   = any_q;

  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_strobe_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r7_any_matches: assert property (@(posedge clk) disable iff (!rst_n)
    any_err == (err_flags != '0));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(err_flags) && $stable(any_err)));
endmodule

// File: tb/fft_dc_err_det_bench.sv
module fft_dc_err_det_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [95:0] samples;
  logic [31:0] dc_re;
  logic [31:0] dc_im;
  logic        out_valid;
  logic [3:0]  err_flags;
  logic        any_err;

  int n_checks = 0;
  int n_fail   = 0;

  logic signed [5:0] smp [NL][NP];
  logic [7:0]        dre [NL];
  logic [7:0]        dim [NL];
  logic [3:0]        last_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  fft_dc_err_det u_fft_dc_err_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .samples   (samples),
    .dc_re     (dc_re),
    .dc_im     (dc_im),
    .out_valid (out_valid),
    .err_flags (err_flags),
    .any_err   (any_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lane_sum(input int l);
    int s = 0;
    for (int k = 0; k < NP; k++) s += int'(smp[l][k]);
    return 8'(s);
  endfunction

  function automatic logic [3:0] expect_flags();
    logic [3:0] e;
    for (int l = 0; l < NL; l++) e[l] = (lane_sum(l) != dre[l]) || (dim[l] != 8'd0);
    return e;
  endfunction

  task automatic pack();
    for (int l = 0; l < NL; l++) begin
      for (int k = 0; k < NP; k++) samples[(l*NP+k)*6 +: 6] = smp[l][k];
      dc_re[l*8 +: 8] = dre[l];
      dc_im[l*8 +: 8] = dim[l];
    end
  endtask

  task automatic set_all(input int base);
    for (int l = 0; l < NL; l++) begin
      for (int k = 0; k < NP; k++) smp[l][k] = 6'(base + 7*l - 5*k);
      dre[l] = lane_sum(l);
      dim[l] = 8'd0;
    end
  endtask

  task automatic strobe(input string req, input bit keep);
    @(negedge clk);
    pack();
    in_valid = 1'b1;
    last_exp = expect_flags();
    @(posedge clk); #1;
    check({req, " R2 valid"}, 32'(out_valid), 32'd1);
    check({req, " flags"}, 32'(err_flags), 32'(last_exp));
    check({req, " R7 any"}, 32'(any_err), 32'(|last_exp));
    if (!keep) begin
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk); #1;
      check({req, " R2 drop"}, 32'(out_valid), 32'd0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; samples = '0; dc_re = '0; dc_im = '0;
    #(CLK_PERIOD*2 + 3);
    check("R1 valid", 32'(out_valid), 32'd0);
    check("R1 flags", 32'(err_flags), 32'd0);
    check("R1 any", 32'(any_err), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 post valid", 32'(out_valid), 32'd0);
    check("R1 post flags", 32'(err_flags), 32'd0);
  endtask

  task automatic t_clean();
    set_all(3);  strobe("R5 clean a", 1'b0);
    set_all(-9); strobe("R5 clean b", 1'b0);
  endtask

  task automatic t_single();
    set_all(1); dre[2] = dre[2] + 8'd1; strobe("R3 lane2", 1'b0);
    check("R3 lane2 bit", 32'(err_flags), 32'h4);
    set_all(2); dre[0] = dre[0] ^ 8'h80; strobe("R3 lane0 msb", 1'b0);
  endtask

  task automatic t_imag();
    set_all(4); dim[0] = 8'd1; strobe("R4 imag lane0", 1'b0);
    check("R4 imag bit", 32'(err_flags), 32'h1);
    set_all(4); dim[3] = 8'h80; strobe("R4 imag lane3", 1'b0);
  endtask

  task automatic t_multi();
    set_all(5); dre[1] = dre[1] - 8'd3; dre[3] = 8'd0; dim[3] = 8'd0;
    strobe("R6 lanes13", 1'b0);
    check("R6 lanes13 bits", 32'(err_flags), 32'(last_exp));
    set_all(0); for (int l = 0; l < NL; l++) dim[l] = 8'd2;
    strobe("R6 all lanes", 1'b0);
    check("R6 all bits", 32'(err_flags), 32'hF);
  endtask

  task automatic t_extremes();
    for (int l = 0; l < NL; l++) begin
      for (int k = 0; k < NP; k++) smp[l][k] = (l < 2) ? -6'sd32 : 6'sd31;
      dre[l] = (l < 2) ? 8'h80 : 8'd124;
      dim[l] = 8'd0;
    end
    strobe("R5 extremes", 1'b0);
    check("R5 extremes zero", 32'(err_flags), 32'd0);
    dre[3] = 8'd123;
    strobe("R3 near max", 1'b0);
    check("R3 near max bit", 32'(err_flags), 32'h8);
  endtask

  task automatic t_hold();
    set_all(6); dre[1] = 8'd0; dre[1] = lane_sum(1) + 8'd9;
    strobe("R8 setup", 1'b0);
    @(negedge clk);
    set_all(6); pack();
    @(posedge clk); #1;
    check("R8 hold flags", 32'(err_flags), 32'h2);
    check("R8 hold any", 32'(any_err), 32'd1);
    @(negedge clk);
    for (int l = 0; l < NL; l++) dim[l] = 8'hFF;
    pack();
    @(posedge clk); #1;
    check("R8 hold flags 2", 32'(err_flags), 32'h2);
    check("R8 hold valid", 32'(out_valid), 32'd0);
  endtask

  task automatic t_back_to_back();
    set_all(7); dim[2] = 8'd5; strobe("R2 b2b first", 1'b1);
    set_all(8); strobe("R2 b2b second", 1'b0);
    check("R2 b2b cleared", 32'(err_flags), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    fork
      begin
        t_reset();
        t_clean();
        t_single();
        t_imag();
        t_multi();
        t_extremes();
        t_hold();
        t_back_to_back();
      end
      begin
        #(CLK_PERIOD*5000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule